// File: doc/BRIEF.md
# Pixel-Count Display Timing Generator

This block generates the sync, data-enable and pixel stream for an external digital display from a single pixel clock. The horizontal position is a pixel counter that restarts at each line. The vertical position is not a line counter. It is a second counter that runs through every pixel clock of the frame. The vertical sync pulse and the vertical display window are compared against that frame count. A programmable skew therefore places the vertical edges at any pixel offset from the horizontal sync.

Software programs the block through a simple write-only bus of 32-bit words. The timing words are held in a pending set. They are copied into the active set while the generator is stopped, and also on the last pixel clock of each frame, so a frame never mixes two timings. Each display pixel comes from one of three places: the upstream stream, a border colour outside an optional sub-window, or an underflow colour when the stream has no pixel ready.

The timing side is a two-state machine. In CNT_OFF both counters are held at zero. CNT_OFF goes to CNT_RUN when the run bit is set. CNT_RUN goes back to CNT_OFF, clearing the counters, when the run bit is cleared.

The underflow side is a three-state machine:
- UF_NORMAL goes to UF_HOLD when an underrun occurs and recovery is enabled.
- UF_HOLD goes to UF_WAIT when the stream is valid again. It goes straight to UF_NORMAL if that happens on the last clock of a line.
- UF_WAIT goes to UF_NORMAL on the last clock of a line.
- Every state returns to UF_NORMAL when the generator is not running.

Top module: `pxcnt_timing_gen`

## Requirements
- R1: Writes take effect when `wr_en` is high on a clock edge, and load `wr_data` into the word at `wr_addr`. The address map is: 0 run bit (bit 0), 1 line control, 2 frame length, 3 vsync width, 4 horizontal window, 5 vertical start, 6 vertical end, 7 polarity, 8 border colour, 9 underflow colour, 10 skew, 11 sub-window horizontal, 12 sub-window enable (bit 0), 13 sub-window vertical start, 14 sub-window vertical end. Setting the run bit while stopped raises `frame_start` in the second cycle after the write edge.
- R2: Out of reset, and from the first cycle after the run bit is cleared, the generator does the following. Both counters are zero. `frame_start`, `src_ready` and `pix_out` are zero. Each of `hsync`, `vsync` and `de` sits at its inactive level, which is its polarity bit.
- R3: The line count runs from 0 to P-1 and then wraps, where P is line-control bits 31:16. `hsync` is asserted while the line count is below line-control bits 15:0.
- R4: The frame count runs from 0 to L-1 and then wraps, where L is word 2. `frame_start` is high for exactly the one cycle in which the running frame count is 0, so it repeats every L cycles.
- R5: `vsync` is asserted while the frame count is at least the skew (word 10) and below the skew plus the vsync width (word 3).
- R6: `de` is asserted when both of these hold:
  - the line count is within horizontal-window bits 15:0 (start) and 31:16 (end), inclusive;
  - the frame count is within words 5 and 6, inclusive.
- R7: Polarity bit 0 inverts `hsync`, bit 1 inverts `vsync` and bit 2 inverts `de`. Polarity changes take effect on the next cycle, even while running.
- R8: `src_ready` is high on display pixels that take data from the stream. On such a pixel with `src_valid` high, `pix_out` equals `src_data`. Outside the display window `pix_out` is 0.
- R9: When the sub-window is enabled (word 12 bit 0), it is bounded by the following limits, all inclusive:
  - a line-count range from word 11 bits 15:0 to bits 31:16;
  - a frame-count range from word 13 to word 14.
  Display pixels outside it show the border colour (word 8) and drop `src_ready`.
- R10: With recovery off (word 9 bit 31 clear), only the cycles in which `src_valid` is low show the underflow colour (word 9 low bits).
- R11: With recovery on, an underrun shows the underflow colour and holds `src_ready` low for the rest of that line. The stream resumes from the start of the next line, provided `src_valid` returned high before the last clock of the line.
- R12: While running, writes to words 1–6 and 10–14 take effect from the next frame start, so the current frame keeps its length. Words 7–9 take effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 32 | Register write data |
| src_valid | input | 1 | Upstream pixel available |
| src_data | input | PIX_W | Upstream pixel value |
| src_ready | output | 1 | Pixel taken from upstream this cycle |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pix_out | output | PIX_W | Pixel to the display port |
| frame_start | output | 1 | One-cycle pulse at frame count zero |

## Verification
The embedded assertions watch four behaviours on every cycle:
- counters being cleared when stopped;
- `frame_start` never lasting two cycles;
- the active timing set staying frozen outside load points;
- the underflow machine leaving its hold only at a line start, and dropping `src_ready` right after a recoverable underrun.

Only the directed scenarios can show the rest. That covers the exact placement of the sync and enable windows across a whole frame, and the skewed vsync against the line count. It also covers border versus stream selection inside the sub-window, the extent of the underflow fill, and the one-frame delay of a timing rewrite.

// File: rtl/pxtg_pkg.sv
package pxtg_pkg;
    parameter int unsigned TG_H_W = 16;
    parameter int unsigned TG_F_W = 24;

    localparam logic [3:0] A_RUN   = 4'd0;
    localparam logic [3:0] A_HCTL  = 4'd1;
    localparam logic [3:0] A_FLEN  = 4'd2;
    localparam logic [3:0] A_VSW   = 4'd3;
    localparam logic [3:0] A_HWIN  = 4'd4;
    localparam logic [3:0] A_VBEG  = 4'd5;
    localparam logic [3:0] A_VFIN  = 4'd6;
    localparam logic [3:0] A_POL   = 4'd7;
    localparam logic [3:0] A_BRD   = 4'd8;
    localparam logic [3:0] A_UFL   = 4'd9;
    localparam logic [3:0] A_SKEW  = 4'd10;
    localparam logic [3:0] A_SWH   = 4'd11;
    localparam logic [3:0] A_SWEN  = 4'd12;
    localparam logic [3:0] A_SWVB  = 4'd13;
    localparam logic [3:0] A_SWVF  = 4'd14;

    typedef struct packed {
        logic [TG_H_W-1:0] line_len;
        logic [TG_H_W-1:0] hs_width;
        logic [TG_H_W-1:0] hw_beg;
        logic [TG_H_W-1:0] hw_fin;
        logic [TG_H_W-1:0] sw_hbeg;
        logic [TG_H_W-1:0] sw_hfin;
        logic [TG_F_W-1:0] frame_len;
        logic [TG_F_W-1:0] vs_width;
        logic [TG_F_W-1:0] vw_beg;
        logic [TG_F_W-1:0] vw_fin;
        logic [TG_F_W-1:0] skew;
        logic [TG_F_W-1:0] sw_vbeg;
        logic [TG_F_W-1:0] sw_vfin;
        logic              sw_en;
    } tg_timing_t;

    typedef enum logic {CNT_OFF, CNT_RUN} cnt_state_e;
    typedef enum logic [1:0] {UF_NORMAL, UF_HOLD, UF_WAIT} uf_state_e;
endpackage

// File: rtl/pxtg_regs.sv
module pxtg_regs
    import pxtg_pkg::*;
#(
    parameter int unsigned PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             load,
    output logic             run,
    output tg_timing_t       act,
    output logic [2:0]       pol,
    output logic [PIX_W-1:0] border,
    output logic [PIX_W-1:0] uf_colour,
    output logic             uf_recover
);
    tg_timing_t pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend       <= '0;
            run        <= 1'b0;
            pol        <= '0;
            border     <= '0;
            uf_colour  <= '0;
            uf_recover <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                A_RUN:  run            <= wr_data[0];
                A_HCTL: begin
                    pend.line_len <= wr_data[16 +: TG_H_W];
                    pend.hs_width <= wr_data[0 +: TG_H_W];
                end
                A_FLEN: pend.frame_len <= wr_data[0 +: TG_F_W];
                A_VSW:  pend.vs_width  <= wr_data[0 +: TG_F_W];
                A_HWIN: begin
                    pend.hw_fin <= wr_data[16 +: TG_H_W];
                    pend.hw_beg <= wr_data[0 +: TG_H_W];
                end
                A_VBEG: pend.vw_beg    <= wr_data[0 +: TG_F_W];
                A_VFIN: pend.vw_fin    <= wr_data[0 +: TG_F_W];
                A_POL:  pol            <= wr_data[2:0];
                A_BRD:  border         <= wr_data[0 +: PIX_W];
                A_UFL: begin
                    uf_colour  <= wr_data[0 +: PIX_W];
                    uf_recover <= wr_data[31];
                end
                A_SKEW: pend.skew      <= wr_data[0 +: TG_F_W];
                A_SWH: begin
                    pend.sw_hfin <= wr_data[16 +: TG_H_W];
                    pend.sw_hbeg <= wr_data[0 +: TG_H_W];
                end
                A_SWEN: pend.sw_en     <= wr_data[0];
                A_SWVB: pend.sw_vbeg   <= wr_data[0 +: TG_F_W];
                A_SWVF: pend.sw_vfin   <= wr_data[0 +: TG_F_W];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            act <= '0;
        else if (load)
            act <= pend;
    end

    // R12
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(act));
endmodule

// File: rtl/pxtg_counters.sv
module pxtg_counters
    import pxtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [TG_H_W-1:0] line_len,
    input  logic [TG_F_W-1:0] frame_len,
    output logic [TG_H_W-1:0] hcnt,
    output logic [TG_F_W-1:0] fcnt,
    output logic              running,
    output logic              line_last,
    output logic              load,
    output logic              frame_start
);
    cnt_state_e st, st_nxt;
    logic       frame_last;

    assign line_last  = (hcnt == line_len - 1'b1);
    assign frame_last = (fcnt == frame_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CNT_OFF;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            CNT_OFF: if (run)  st_nxt = CNT_RUN;
            CNT_RUN: if (!run) st_nxt = CNT_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            fcnt <= '0;
        end else if (st == CNT_RUN && run) begin
            hcnt <= line_last  ? '0 : hcnt + 1'b1;
            fcnt <= frame_last ? '0 : fcnt + 1'b1;
        end else begin
            hcnt <= '0;
            fcnt <= '0;
        end
    end

    always_comb begin
        running     = (st == CNT_RUN) && run;
        load        = (st == CNT_OFF) || (running && frame_last);
        frame_start = running && (fcnt == '0);
    end

    // R2
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hcnt == '0 && fcnt == '0));

    // R4
    sof_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);
endmodule

// File: rtl/pxtg_pixel.sv
module pxtg_pixel
    import pxtg_pkg::*;
#(
    parameter int unsigned PIX_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic              line_last,
    input  logic [TG_H_W-1:0] hcnt,
    input  logic [TG_F_W-1:0] fcnt,
    input  tg_timing_t        tm,
    input  logic [2:0]        pol,
    input  logic [PIX_W-1:0]  border,
    input  logic [PIX_W-1:0]  uf_colour,
    input  logic              uf_recover,
    input  logic              src_valid,
    input  logic [PIX_W-1:0]  src_data,
    output logic              src_ready,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [PIX_W-1:0]  pix_out
);
    uf_state_e uf_st, uf_nxt;
    logic hs_act, vs_act, de_act, in_sub, underrun;
    logic [TG_F_W:0] vs_end;

    always_comb begin
        vs_end   = {1'b0, tm.skew} + {1'b0, tm.vs_width};
        hs_act   = running && (hcnt < tm.hs_width);
        vs_act   = running && (fcnt >= tm.skew) && ({1'b0, fcnt} < vs_end);
        de_act   = running && (hcnt >= tm.hw_beg) && (hcnt <= tm.hw_fin)
                           && (fcnt >= tm.vw_beg) && (fcnt <= tm.vw_fin);
        in_sub   = !tm.sw_en ||
                   ((hcnt >= tm.sw_hbeg) && (hcnt <= tm.sw_hfin) &&
                    (fcnt >= tm.sw_vbeg) && (fcnt <= tm.sw_vfin));
        src_ready = de_act && in_sub && (uf_st == UF_NORMAL);
        underrun  = src_ready && !src_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) uf_st <= UF_NORMAL;
        else        uf_st <= uf_nxt;
    end

    always_comb begin
        uf_nxt = uf_st;
        unique case (uf_st)
            UF_NORMAL: if (underrun && uf_recover) uf_nxt = UF_HOLD;
            UF_HOLD:   if (src_valid) uf_nxt = line_last ? UF_NORMAL : UF_WAIT;
            UF_WAIT:   if (line_last) uf_nxt = UF_NORMAL;
            default:   uf_nxt = UF_NORMAL;
        endcase
        if (!running) uf_nxt = UF_NORMAL;
    end

    always_comb begin
        hsync = hs_act ^ pol[0];
        vsync = vs_act ^ pol[1];
        de    = de_act ^ pol[2];
        if (!de_act)
            pix_out = '0;
        else if (!in_sub)
            pix_out = border;
        else if (uf_st != UF_NORMAL || !src_valid)
            pix_out = uf_colour;
        else
            pix_out = src_data;
    end

    // R11
    uf_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && uf_st == UF_NORMAL && $past(uf_st) != UF_NORMAL) |-> hcnt == '0);

    // R11
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready && !src_valid && uf_recover) |=> !src_ready);
endmodule

// File: rtl/pxcnt_timing_gen.sv
module pxcnt_timing_gen
    import pxtg_pkg::*;
#(
    parameter int unsigned PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic             src_valid,
    input  logic [PIX_W-1:0] src_data,
    output logic             src_ready,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [PIX_W-1:0] pix_out,
    output logic             frame_start
);
    tg_timing_t        act;
    logic              run, load, running, line_last, uf_recover;
    logic [2:0]        pol;
    logic [PIX_W-1:0]  border, uf_colour;
    logic [TG_H_W-1:0] hcnt;
    logic [TG_F_W-1:0] fcnt;

    pxtg_regs #(.PIX_W(PIX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load), .run(run), .act(act), .pol(pol),
        .border(border), .uf_colour(uf_colour), .uf_recover(uf_recover)
    );

    pxtg_counters u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .line_len(act.line_len),
        .frame_len(act.frame_len), .hcnt(hcnt), .fcnt(fcnt),
        .running(running), .line_last(line_last), .load(load),
        .frame_start(frame_start)
    );

    pxtg_pixel #(.PIX_W(PIX_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .running(running), .line_last(line_last),
        .hcnt(hcnt), .fcnt(fcnt), .tm(act), .pol(pol), .border(border),
        .uf_colour(uf_colour), .uf_recover(uf_recover),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out)
    );
endmodule

// File: tb/pxcnt_timing_gen_tb.sv
`timescale 1ns/1ps
module pxcnt_timing_gen_tb;
    localparam int PW  = 24;
    localparam int P   = 10, HSW = 2, HB = 4, HF = 7;
    localparam int L   = 60, VSW = 10, SK = 3, VB = 23, VF = 52;
    localparam logic [PW-1:0] SRC = 24'h123456, BRD = 24'h00FF00, UFC = 24'hFF0000;

    logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, src_valid = 1'b1;
    logic [3:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [PW-1:0] src_data = SRC;
    logic src_ready, hsync, vsync, de, frame_start;
    logic [PW-1:0] pix_out;
    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 1'b0;

    pxcnt_timing_gen #(.PIX_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out), .frame_start(frame_start)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_sof();
        int n = 0;
        @(negedge clk);
        while (!frame_start && n < 300) begin @(negedge clk); n++; end
        chk("R4 frame_start seen", {31'b0, frame_start}, 32'd1);
    endtask

    // mode: 0 plain, 1 underrun no recovery, 2 underrun with recovery
    task automatic scan(input string tag, input bit inv, input bit sub, input int mode);
        int e_hs = 0, e_vs = 0, e_de = 0, e_px = 0, e_rd = 0, e_sf = 0;
        for (int i = 0; i < L; i++) begin
            int h = i % P;
            bit xhs, xvs, xde, xin, xrd;
            logic [PW-1:0] xpx;
            src_valid = !(mode != 0 && i == 25);
            #1;
            xhs = h < HSW;
            xvs = (i >= SK) && (i < SK + VSW);
            xde = (h >= HB) && (h <= HF) && (i >= VB) && (i <= VF);
            xin = !sub || ((h >= 5) && (h <= 6) && (i >= 33) && (i <= 42));
            xrd = xde && xin && !(mode == 2 && (i == 26 || i == 27));
            if (!xde)                                   xpx = '0;
            else if (!xin)                              xpx = BRD;
            else if (mode == 1 && i == 25)              xpx = UFC;
            else if (mode == 2 && i >= 25 && i <= 27)   xpx = UFC;
            else                                        xpx = SRC;
            if (hsync != (xhs ^ inv)) e_hs++;
            if (vsync != (xvs ^ inv)) e_vs++;
            if (de != (xde ^ inv))    e_de++;
            if (pix_out !== xpx)      e_px++;
            if (src_ready != xrd)     e_rd++;
            if (frame_start != (i == 0)) e_sf++;
            @(negedge clk);
        end
        src_valid = 1'b1;
        chk({tag, " R3 hsync mismatches"}, e_hs, 0);
        chk({tag, " R5 vsync mismatches"}, e_vs, 0);
        chk({tag, " R6 de mismatches"}, e_de, 0);
        chk({tag, " R8 pixel mismatches"}, e_px, 0);
        chk({tag, " R8 src_ready mismatches"}, e_rd, 0);
        chk({tag, " R4 frame_start mismatches"}, e_sf, 0);
        chk({tag, " R4 frame_start after L cycles"}, {31'b0, frame_start}, 32'd1);
    endtask

    task automatic t_reset();
        chk("R2 reset hsync", {31'b0, hsync}, 0);
        chk("R2 reset vsync", {31'b0, vsync}, 0);
        chk("R2 reset de", {31'b0, de}, 0);
        chk("R2 reset frame_start", {31'b0, frame_start}, 0);
        chk("R2 reset src_ready", {31'b0, src_ready}, 0);
        chk("R2 reset pix_out", {8'b0, pix_out}, 0);
    endtask

    task automatic t_config();
        wr(4'd1, (P << 16) | HSW);
        wr(4'd2, L);
        wr(4'd3, VSW);
        wr(4'd4, (HF << 16) | HB);
        wr(4'd5, VB);
        wr(4'd6, VF);
        wr(4'd10, SK);
        wr(4'd8, {8'b0, BRD});
        wr(4'd9, {8'b0, UFC});
        wr(4'd11, (6 << 16) | 5);
        wr(4'd13, 33);
        wr(4'd14, 42);
    endtask

    task automatic t_pol_idle();
        wr(4'd7, 7);
        @(negedge clk);
        chk("R7 R2 idle hsync inverted", {31'b0, hsync}, 1);
        chk("R7 R2 idle vsync inverted", {31'b0, vsync}, 1);
        chk("R7 R2 idle de inverted", {31'b0, de}, 1);
        wr(4'd7, 0);
        @(negedge clk);
        chk("R7 idle de restored", {31'b0, de}, 0);
    endtask

    task automatic t_enable();
        wr(4'd0, 1);
        @(negedge clk);
        chk("R1 no frame_start one cycle after enable", {31'b0, frame_start}, 0);
        @(negedge clk);
        chk("R1 frame_start two cycles after enable", {31'b0, frame_start}, 1);
    endtask

    task automatic t_polarity();
        wr(4'd7, 7);
        wait_sof();
        scan("R7 inverted", 1'b1, 1'b0, 0);
        wr(4'd7, 0);
        wait_sof();
    endtask

    task automatic t_subwin();
        wr(4'd12, 1);
        wait_sof();
        scan("R9 subwindow", 1'b0, 1'b1, 0);
        wr(4'd12, 0);
        wait_sof();
        scan("R9 subwindow off", 1'b0, 1'b0, 0);
    endtask

    task automatic t_underflow();
        wait_sof();
        scan("R10 no recovery", 1'b0, 1'b0, 1);
        wr(4'd9, 32'h8000_0000 | {8'b0, UFC});
        wait_sof();
        scan("R11 recovery", 1'b0, 1'b0, 2);
    endtask

    task automatic t_shadow();
        int c0, c1, c2;
        wait_sof();
        c0 = cyc;
        wr(4'd2, 70);
        wait_sof(); c1 = cyc;
        chk("R12 current frame keeps old length", c1 - c0, 60);
        wait_sof(); c2 = cyc;
        chk("R12 next frame uses new length", c2 - c1, 70);
        wr(4'd2, L);
        wait_sof();
        wait_sof();
        scan("R12 restored", 1'b0, 1'b0, 0);
    endtask

    task automatic t_disable();
        int seen = 0;
        repeat (7) @(negedge clk);
        wr(4'd0, 0);
        @(negedge clk);
        chk("R2 stop hsync", {31'b0, hsync}, 0);
        chk("R2 stop vsync", {31'b0, vsync}, 0);
        chk("R2 stop de", {31'b0, de}, 0);
        chk("R2 stop src_ready", {31'b0, src_ready}, 0);
        chk("R2 stop pix_out", {8'b0, pix_out}, 0);
        for (int k = 0; k < 100; k++) begin
            if (frame_start) seen++;
            @(negedge clk);
        end
        chk("R2 stop no frame_start", seen, 0);
        t_enable();
        scan("R1 restart", 1'b0, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_pol_idle();
        t_enable();
        scan("R3 base frame", 1'b0, 1'b0, 0);
        t_polarity();
        t_subwin();
        t_underflow();
        t_shadow();
        t_disable();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule